// File: doc/BRIEF.md
# Triggered Logic Capture Controller

This block records the state of eight logic probe lines into an on-chip sample store of 4096 bytes. A free-running prescaler turns the system clock into a sample tick whose rate falls by a factor of four at each step of a seven-step ladder, or the tick can come from an outside strobe. An edge detector can hold off recording until a chosen probe line, or an outside pattern-match line, makes a rising or falling transition. Once it has armed and fired, the block stores one sample per tick until the store is full.

The host drives the block through a small command port: stop, clear, start with a 10-bit setup word, and rewind of the read position. It polls a status byte for the full condition and then pulls the samples out one strobe at a time, oldest first. Two setup bits that belong to the board's input stage (supply level and pull direction) are only held and driven out.

Top module: `logic_capture_ctrl`

## Requirements
- R1: The store holds 4096 eight-bit samples; `full` goes high on the clock edge that performs the 4096th write since the last clear, and no sample is written while `full` is high.
- R2: Setup bits [2:0] pick the tick source: code 0 takes one sample for every clock in which `ext_tick` is high; codes 1 to 7 give one tick every 1, 4, 16, 64, 256, 1024 and 4096 clocks, the tick falling in the clock where the number of clocks since `rst_n` went high, modulo that ratio, equals the ratio minus one.
- R3: Setup bits [6:3] pick the trigger source: 0 records from the first tick with no trigger, n from 1 to 8 watches `probe_in[n-1]`, 9 watches `pattern_hit`, and 10 to 15 never fire, so nothing is recorded.
- R4: Setup bit 7 picks the edge (0 rising, 1 falling), found by comparing the source value at one tick with its value at the previous tick; the first tick after a start only records the reference value. The sample taken at the tick that sees the edge is the first one stored, and the trigger stays fired until a clear.
- R5: A start command (op 2) loads the setup word and begins running from the next clock; a stop command (op 0) halts running, so ticks store nothing until the next start.
- R6: A clear command (op 1) zeroes both the write and read positions, the trigger, `full` and `rd_data`, and stops running; a read strobe in the same clock is dropped.
- R7: `status_byte` reads 8'h80 while the store is full and 8'h00 otherwise.
- R8: While full, each clock with `rd_strobe` high places the next stored sample on `rd_data` one clock later, starting at address 0 in write order; a strobe while not full, or after all 4096 samples were read, drives `rd_data` to 8'h00 without moving the read position; a rewind command (op 3) returns the read position to 0.
- R9: Setup bits 8 and 9 appear on `supply_sel` and `pull_sel` from the clock after a start and are 0 after `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| probe_in | input | 8 | Logic lines being recorded |
| pattern_hit | input | 1 | Outside pattern-match line, trigger source 9 |
| ext_tick | input | 1 | Outside sample strobe, used with rate code 0 |
| cmd_valid | input | 1 | Command present this clock |
| cmd_op | input | 2 | 0 stop, 1 clear, 2 start, 3 rewind |
| cfg_word | input | 10 | Setup word, loaded on start |
| rd_strobe | input | 1 | Request the next stored sample |
| rd_data | output | 8 | Sample returned one clock after a strobe |
| full | output | 1 | Store holds 4096 samples |
| status_byte | output | 8 | 8'h80 when full, else 8'h00 |
| supply_sel | output | 1 | Held setup bit 8 |
| pull_sel | output | 1 | Held setup bit 9 |

## Verification
The bench aims at the sample taken on the triggering tick: a design that delayed the write by one tick would return the value after the edge as the first sample, and one that let the stale reference from an earlier run fire would record before the edge. It runs the store to exactly 4096 writes and reads one past the end, where an off-by-one in either pointer shows as a late or early `full` or a wrapped read returning address 0 instead of 8'h00. It also pauses a run with a stop and resumes it, selects an unused trigger code, and uses the outside strobe and the pattern line, so a design that kept counting while stopped or treated codes above 9 as free-run would fill when it must not.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  localparam int LCC_CHANNELS    = 8;
  localparam int LCC_PATTERN_SRC = LCC_CHANNELS + 1;
  localparam int LCC_RATE_CODES  = 8;

  typedef enum logic [1:0] {
    OP_STOP   = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_START  = 2'd2,
    OP_REWIND = 2'd3
  } lcc_op_e;

  typedef struct packed {
    logic       pull_up;
    logic       supply_hi;
    logic       falling;
    logic [3:0] src;
    logic [2:0] rate;
  } lcc_cfg_t;

  // Low-bit mask of the prescaler that marks a tick: ratio 4^(code-1).
  function automatic int unsigned rate_mask(input logic [2:0] code);
    if (code == 3'd0) return 0;
    return (32'd1 << (2 * (int'(code) - 1))) - 32'd1;
  endfunction

  function automatic logic source_valid(input logic [3:0] src);
    return (src >= 4'd1) && (int'(src) <= LCC_PATTERN_SRC);
  endfunction

  function automatic logic source_bit(input logic [3:0] src,
                                      input logic [LCC_CHANNELS-1:0] probe,
                                      input logic pattern);
    if (int'(src) == LCC_PATTERN_SRC) return pattern;
    if (src >= 4'd1 && int'(src) <= LCC_CHANNELS) return probe[3'(src - 4'd1)];
    return 1'b0;
  endfunction

  function automatic logic edge_hit(input logic prev, input logic cur,
                                    input logic falling);
    return falling ? (prev & ~cur) : (~prev & cur);
  endfunction

endpackage

// File: rtl/lcc_prescaler.sv
module lcc_prescaler
  import lcc_pkg::*;
#(
  parameter int CNT_W = 2 * (LCC_RATE_CODES - 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_code,
  input  logic       ext_tick,
  output logic       tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_comb begin
    mask = CNT_W'(rate_mask(rate_code));
    if (rate_code == 3'd0) tick = ext_tick;
    else                   tick = ((cnt & mask) == mask);
  end

endmodule

// File: rtl/lcc_trigger.sv
module lcc_trigger
  import lcc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    running,
  input  logic                    clear,
  input  logic                    arm,
  input  logic [3:0]              src,
  input  logic                    falling,
  input  logic [LCC_CHANNELS-1:0] probe,
  input  logic                    pattern_hit,
  output logic                    capture_ok,
  output logic                    edge_now,
  output logic                    latched
);

  logic cur;
  logic prev;
  logic prev_valid;

  always_comb begin
    cur        = source_bit(src, probe, pattern_hit);
    edge_now   = tick & running & prev_valid & source_valid(src) &
                 edge_hit(prev, cur, falling);
    capture_ok = (src == 4'd0) | latched | edge_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev       <= 1'b0;
      prev_valid <= 1'b0;
      latched    <= 1'b0;
    end else if (clear) begin
      prev_valid <= 1'b0;
      latched    <= 1'b0;
    end else if (arm) begin
      prev_valid <= 1'b0;
    end else if (tick && running) begin
      prev       <= cur;
      prev_valid <= 1'b1;
      if (edge_now) latched <= 1'b1;
    end
  end

endmodule

// File: rtl/lcc_store.sv
module lcc_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rewind,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              full
);

  localparam int                DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic              rd_done;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      full    <= 1'b0;
    end else if (clear) begin
      wr_ptr  <= '0;
      full    <= 1'b0;
    end else if (wr_en) begin
      wr_ptr  <= wr_ptr + 1'b1;
      if (wr_ptr == LAST) full <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else if (clear) begin
      rd_ptr  <= '0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else if (rewind) begin
      rd_ptr  <= '0;
      rd_done <= 1'b0;
    end else if (rd_strobe) begin
      if (full && !rd_done) begin
        rd_data <= mem[rd_ptr];
        rd_ptr  <= rd_ptr + 1'b1;
        if (rd_ptr == LAST) rd_done <= 1'b1;
      end else begin
        rd_data <= '0;
      end
    end
  end

endmodule

// File: rtl/logic_capture_ctrl.sv
module logic_capture_ctrl
  import lcc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] probe_in,
  input  logic       pattern_hit,
  input  logic       ext_tick,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [9:0] cfg_word,
  input  logic       rd_strobe,
  output logic [7:0] rd_data,
  output logic       full,
  output logic [7:0] status_byte,
  output logic       supply_sel,
  output logic       pull_sel
);

  localparam int PRESCALE_W = 2 * (LCC_RATE_CODES - 2);

  lcc_cfg_t cfg_q;
  logic     run;
  logic     do_stop, do_clear, do_start, do_rewind;
  logic     tick, capture_ok, edge_now, trig_latched, wr_en;

  always_comb begin
    do_stop   = cmd_valid && (cmd_op == OP_STOP);
    do_clear  = cmd_valid && (cmd_op == OP_CLEAR);
    do_start  = cmd_valid && (cmd_op == OP_START);
    do_rewind = cmd_valid && (cmd_op == OP_REWIND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cfg_q <= '0;
    end else if (do_clear || do_stop) begin
      run   <= 1'b0;
    end else if (do_start) begin
      run   <= 1'b1;
      cfg_q <= lcc_cfg_t'(cfg_word);
    end
  end

  lcc_prescaler #(.CNT_W(PRESCALE_W)) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_code (cfg_q.rate),
    .ext_tick  (ext_tick),
    .tick      (tick)
  );

  lcc_trigger u_trigger (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .running     (run),
    .clear       (do_clear),
    .arm         (do_start),
    .src         (cfg_q.src),
    .falling     (cfg_q.falling),
    .probe       (probe_in),
    .pattern_hit (pattern_hit),
    .capture_ok  (capture_ok),
    .edge_now    (edge_now),
    .latched     (trig_latched)
  );

  assign wr_en = tick & run & ~full & capture_ok & ~do_clear;

  lcc_store #(.ADDR_W(ADDR_W), .DATA_W(LCC_CHANNELS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (do_clear),
    .rewind    (do_rewind),
    .wr_en     (wr_en),
    .wr_data   (probe_in),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .full      (full)
  );

  assign status_byte = {full, 7'b0};
  assign supply_sel  = cfg_q.supply_hi;
  assign pull_sel    = cfg_q.pull_up;

endmodule

// File: rtl/lcc_checker.sv
module lcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       full,
  input logic       wr_en,
  input logic       run,
  input logic       tick,
  input logic [2:0] rate_code,
  input logic       edge_now,
  input logic       trig_latched,
  input logic       do_clear,
  input logic       do_rewind,
  input logic       rd_strobe,
  input logic [7:0] rd_data
);

  // R1: full only rises on a clock that wrote a sample
  a_r1_full_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_en));

  // R1: nothing is written into a full store
  a_r1_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);

  // R2: the fastest rate ticks on every clock
  a_r2_fastest_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 3'd1) |-> tick);

  // R5: a stopped block never writes
  a_r5_no_write_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !wr_en);

  // R4: an edge is only reported while running
  a_r4_edge_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    edge_now |-> run);

  // R4: the fired trigger holds until a clear
  a_r4_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_latched && !do_clear) |=> trig_latched);

  // R6: clear empties the store, drops the trigger and stops
  a_r6_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> (!full && !trig_latched && !run && rd_data == 8'h00));

  // R8: a strobe on a store that is not full returns zero
  a_r8_read_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !full && !do_clear && !do_rewind) |=> (rd_data == 8'h00));

endmodule

bind logic_capture_ctrl lcc_checker u_lcc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .full         (full),
  .wr_en        (wr_en),
  .run          (run),
  .tick         (tick),
  .rate_code    (cfg_q.rate),
  .edge_now     (edge_now),
  .trig_latched (trig_latched),
  .do_clear     (do_clear),
  .do_rewind    (do_rewind),
  .rd_strobe    (rd_strobe),
  .rd_data      (rd_data)
);

// File: tb/logic_capture_ctrl_test.sv
module logic_capture_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4096;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] probe_in;
  logic       pattern_hit, ext_tick, cmd_valid, rd_strobe;
  logic [1:0] cmd_op;
  logic [9:0] cfg_word;
  logic [7:0] rd_data, status_byte;
  logic       full, supply_sel, pull_sel;

  int  nvec  = 0;
  int  nfail = 0;
  bit  auto_probe = 1'b1;
  bit  ext_mode   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic_capture_ctrl uut (
    .clk(clk), .rst_n(rst_n), .probe_in(probe_in), .pattern_hit(pattern_hit),
    .ext_tick(ext_tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cfg_word(cfg_word), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .full(full), .status_byte(status_byte), .supply_sel(supply_sel),
    .pull_sel(pull_sel)
  );

  // ---------------- reference model ----------------
  int         m_cnt, m_wr, m_rd, ratio;
  bit         m_run, m_fall, m_sup, m_pull, m_full, m_done, m_trig, m_prev, m_pv;
  bit  [2:0]  m_rate;
  bit  [3:0]  m_src;
  logic [7:0] m_rdata;
  logic [7:0] m_mem [DEPTH];
  bit         e_tick, e_cur, e_valid, e_edge, e_wr, e_clr, e_start, e_stop, e_rew;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_wr = 0; m_rd = 0; m_run = 0; m_fall = 0; m_sup = 0; m_pull = 0;
      m_full = 0; m_done = 0; m_trig = 0; m_prev = 0; m_pv = 0; m_rate = 0;
      m_src = 0; m_rdata = 8'h00;
    end else begin
      e_clr   = cmd_valid && cmd_op == 2'd1;
      e_start = cmd_valid && cmd_op == 2'd2;
      e_stop  = cmd_valid && cmd_op == 2'd0;
      e_rew   = cmd_valid && cmd_op == 2'd3;
      ratio = 1;
      for (int k = 1; k < int'(m_rate); k++) ratio = ratio * 4;
      e_tick  = (m_rate == 0) ? ext_tick : ((m_cnt % ratio) == ratio - 1);
      e_valid = (m_src >= 1 && m_src <= 9);
      if (m_src == 9)      e_cur = pattern_hit;
      else if (e_valid)    e_cur = probe_in[m_src - 1];
      else                 e_cur = 1'b0;
      e_edge = e_tick && m_run && m_pv && e_valid &&
               (m_fall ? (m_prev && !e_cur) : (!m_prev && e_cur));
      e_wr = e_tick && m_run && !m_full && !e_clr && (m_src == 0 || m_trig || e_edge);
      // readout
      if (e_clr) begin
        m_rdata = 8'h00; m_rd = 0; m_done = 0;
      end else if (e_rew) begin
        m_rd = 0; m_done = 0;
      end else if (rd_strobe) begin
        if (m_full && !m_done) begin
          m_rdata = m_mem[m_rd];
          m_rd = m_rd + 1;
          if (m_rd == DEPTH) m_done = 1;
        end else m_rdata = 8'h00;
      end
      // recording
      if (e_wr) begin
        m_mem[m_wr] = probe_in;
        m_wr = m_wr + 1;
        if (m_wr == DEPTH) m_full = 1;
      end
      if (e_clr) begin m_wr = 0; m_full = 0; end
      // trigger
      if (e_clr) begin m_trig = 0; m_pv = 0; end
      else if (e_start) m_pv = 0;
      else if (e_tick && m_run) begin
        m_prev = e_cur; m_pv = 1;
        if (e_edge) m_trig = 1;
      end
      // control
      if (e_clr || e_stop) m_run = 0;
      else if (e_start) begin
        m_run = 1; m_rate = cfg_word[2:0]; m_src = cfg_word[6:3];
        m_fall = cfg_word[7]; m_sup = cfg_word[8]; m_pull = cfg_word[9];
      end
      m_cnt = (m_cnt + 1) % DEPTH;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      check("R1 full",        {7'b0, full},       {7'b0, m_full});
      check("R7 status_byte", status_byte,        m_full ? 8'h80 : 8'h00);
      check("R8 rd_data",     rd_data,            m_rdata);
      check("R9 supply_sel",  {7'b0, supply_sel}, {7'b0, m_sup});
      check("R9 pull_sel",    {7'b0, pull_sel},   {7'b0, m_pull});
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
      if (auto_probe) probe_in = probe_in * 8'd5 + 8'd1;
      if (ext_mode)   ext_tick = ~ext_tick;
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [9:0] w);
    cmd_valid = 1'b1; cmd_op = op; cfg_word = w;
    cyc(1);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input int n);
    rd_strobe = 1'b1;
    cyc(n);
    rd_strobe = 1'b0;
  endtask

  task automatic wait_full(input int limit);
    int k = 0;
    while (!full && k < limit) begin cyc(1); k++; end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nfail++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  logic [7:0] first_val;

  initial begin
    rst_n = 1'b0; probe_in = 8'h3C; pattern_hit = 1'b0; ext_tick = 1'b0;
    cmd_valid = 1'b0; cmd_op = 2'd0; cfg_word = '0; rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cyc(2);
    // reset state: R1 R6 R7 R9
    check("R1 reset full", {7'b0, full}, 8'h00);
    check("R6 reset rd_data", rd_data, 8'h00);
    check("R7 reset status", status_byte, 8'h00);
    check("R9 reset supply", {7'b0, supply_sel}, 8'h00);

    // free run at the fastest rate, setup bits 8 and 9 set
    cmd(2'd2, 10'h301);
    first_val = probe_in;
    check("R9 supply after start", {7'b0, supply_sel}, 8'h01);
    check("R9 pull after start",   {7'b0, pull_sel},   8'h01);
    cyc(4095);
    check("R2 R1 not full after 4095 ticks", {7'b0, full}, 8'h00);
    cyc(1);
    check("R1 full after 4096 ticks", {7'b0, full}, 8'h01);
    check("R7 status when full", status_byte, 8'h80);
    rd(1);
    check("R8 first sample", rd_data, first_val);
    rd(DEPTH - 1);
    rd(1);
    check("R8 read past end", rd_data, 8'h00);
    cmd(2'd3, 10'h000);
    rd(1);
    check("R8 rewind to address 0", rd_data, first_val);

    // clear, then reads on an empty store
    cmd(2'd1, 10'h000);
    check("R6 clear full", {7'b0, full}, 8'h00);
    check("R6 clear rd_data", rd_data, 8'h00);
    rd(3);
    check("R8 read while not full", rd_data, 8'h00);

    // falling edge on probe_in[4], rate code 2
    auto_probe = 1'b0; probe_in = 8'h10;
    cmd(2'd2, 10'd170);
    cyc(20);
    check("R4 no capture before edge", {7'b0, full}, 8'h00);
    probe_in = 8'h0A;
    cyc(12);
    auto_probe = 1'b1;
    wait_full(20000);
    check("R4 falling trigger fills", {7'b0, full}, 8'h01);
    rd(1);
    check("R4 triggering sample stored first", rd_data, 8'h0A);
    rd(DEPTH - 1);

    // outside strobe with pattern-match source, rising
    cmd(2'd1, 10'h000);
    ext_mode = 1'b1;
    cmd(2'd2, 10'd72);
    cyc(10);
    check("R3 pattern source idle", {7'b0, full}, 8'h00);
    auto_probe = 1'b0; probe_in = 8'hC3; pattern_hit = 1'b1;
    cyc(6);
    auto_probe = 1'b1;
    wait_full(20000);
    check("R2 outside strobe fills", {7'b0, full}, 8'h01);
    rd(1);
    check("R3 pattern trigger sample", rd_data, 8'hC3);
    rd(DEPTH - 1);
    ext_mode = 1'b0; ext_tick = 1'b0; pattern_hit = 1'b0;

    // stop halts recording, start resumes
    cmd(2'd1, 10'h000);
    cmd(2'd2, 10'h001);
    cyc(100);
    cmd(2'd0, 10'h001);
    cyc(5000);
    check("R5 stopped block stays not full", {7'b0, full}, 8'h00);
    cmd(2'd2, 10'h001);
    wait_full(5000);
    check("R5 resumed run fills", {7'b0, full}, 8'h01);

    // unused trigger code never fires
    cmd(2'd1, 10'h000);
    cmd(2'd2, 10'd97);
    cyc(5000);
    check("R3 source 12 never fires", {7'b0, full}, 8'h00);

    // rate code 3: one tick every 16 clocks
    cmd(2'd1, 10'h000);
    cmd(2'd2, 10'h003);
    cyc(DEPTH * 16 - 20);
    check("R2 divide-16 not yet full", {7'b0, full}, 8'h00);
    cyc(40);
    check("R2 divide-16 full", {7'b0, full}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule